// File: doc/BRIEF.md
# Redundant-Remainder Radix-2 Fractional Divider

This block divides one normalized unsigned fraction by another, producing one quotient digit per clock. The partial remainder never passes through a full-width adder during the iteration. It is held as a pair of words whose sum is the true value. Each cycle, a three-input compressor forms that next pair for every possible digit in parallel. A short four-bit adder over the top of the pair picks the digit from the set {-1, 0, +1}. Because the digit may be negative, the quotient is gathered in two registers: one for positive digits and one for negative digits. A single finishing cycle then resolves the remainder and the quotient with full-width arithmetic and applies a one-step correction.

A user presents the dividend and the divisor and pulses `start` while the block is idle. The operands must have their top bit set. The block raises `busy`, runs `W` iterations, spends one more cycle resolving, and then shows the results together with a one-cycle `done` pulse. The results hold until the next division completes. The operand bus is read only at the accepting edge.

Both operands are read as `W`-bit integers X and D with weight 2^-W. The quotient is floor(X·2^(W-1)/D), which is a fixed-point value with one integer bit and W-1 fraction bits. The remainder is the matching integer left over.

Top module: `bsd_divider`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 latches both operands, and `busy` is 1 from the following cycle. With `start` low and the block idle, `busy` stays 0.
- R3: `done` rises exactly W+1 clock edges after the accepting edge and stays high for one cycle only. `busy` falls on the same edge that `done` rises.
- R4: For operands whose top bit (bit W-1) is set, `quotient` equals floor(X·2^(W-1)/D), where X is the dividend integer and D is the divisor integer.
- R5: `remainder` equals X·2^(W-1) - quotient·D and lies in the range 0 to D-1.
- R6: While `busy` is 1, `start` and any change of the operand inputs have no effect on the running division or on its result.
- R7: `quotient` and `remainder` change only on the edge that raises `done`. Between completions they hold their values, whatever the inputs do.
- R8: Operands that are equal or nearly equal (X = D, X = D±1) give exact results: X = D gives quotient 2^(W-1) and remainder 0.
- R9: At the range limits, the results are exact: X = 2^W-1 with D = 2^(W-1) gives quotient 2^W-1 and remainder 0, and X = 2^(W-1) with D = 2^W-1 is also exact.
- R10: A new `start` may be given in the cycle right after `done` and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a division when idle |
| dividend_i | input | W | Normalized dividend, bit W-1 set |
| divisor_i | input | W | Normalized divisor, bit W-1 set |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | floor(X·2^(W-1)/D) |
| remainder_o | output | W | Integer remainder, below D |

## Verification
The bench builds the divider with W = 8. At that width, the reference X·2^(W-1)/D fits easily in a 64-bit integer. Hundreds of random normalized operand pairs fit in the cycle budget, along with the exact-equality and off-by-one pairs that drive the remainder pair toward zero. The narrow width also lets the few range-limit pairs and the negative-remainder correction appear often among the random cases. The default width of 16 is elaborated for the design alone.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIN  = 2'd2
  } dv_state_e;

  // signed quotient digit: at most one flag set, none means zero
  typedef struct packed {
    logic pos;
    logic neg;
  } digit_t;

endpackage

// File: rtl/bsd_select.sv
// Digit decoder: short assimilation of the top four bits of the doubled
// remainder pair (weights -4, 2, 1, 1/2) and the digit rule.
module bsd_select
  import bsd_pkg::*;
(
  input  logic [3:0] s_top,
  input  logic [3:0] c_top,
  output digit_t     dig
);
  logic [3:0] est;

  always_comb begin
    est     = s_top + c_top;
    // est >= 0 -> +1 ; est == -1/2 -> 0 ; est <= -1 -> -1
    dig.pos = ~est[3];
    dig.neg = est[3] & ~(&est);
  end
endmodule

// File: rtl/bsd_step.sv
// One candidate step: doubles the redundant pair and folds in -DIG*divisor
// with a row of 3:2 compressors, no carry propagation.
module bsd_step #(
  parameter int RW  = 20,
  parameter int DIG = 0
) (
  input  logic [RW-1:0] s_i,
  input  logic [RW-1:0] c_i,
  input  logic [RW-1:0] dv_i,
  output logic [RW-1:0] s_o,
  output logic [RW-1:0] c_o
);
  logic [RW-1:0] s2, c2, addend, maj;
  logic          cin;

  generate
    if (DIG > 0) begin : g_sub
      assign addend = ~dv_i;
      assign cin    = 1'b1;
    end else if (DIG < 0) begin : g_add
      assign addend = dv_i;
      assign cin    = 1'b0;
    end else begin : g_shift
      assign addend = '0;
      assign cin    = 1'b0;
    end
  endgenerate

  always_comb begin
    s2  = {s_i[RW-2:0], 1'b0};
    c2  = {c_i[RW-2:0], 1'b0};
    maj = (s2 & c2) | (s2 & addend) | (c2 & addend);
    s_o = s2 ^ c2 ^ addend;
    c_o = {maj[RW-2:0], cin};
  end
endmodule

// File: rtl/bsd_divider.sv
module bsd_divider
  import bsd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  // remainder: sign + 2 integer bits + (W+1) fraction bits
  localparam int RW = W + 4;
  localparam int CW = $clog2(W + 1);
  localparam int QW = W + 2;

  dv_state_e       state_q;
  logic [RW-1:0]   s_q, c_q, dv_q;
  logic [W-1:0]    p_q, m_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q;
  logic [W-1:0]    quot_q, rem_q;

  logic [RW-1:0]   cand_s [3];
  logic [RW-1:0]   cand_c [3];
  digit_t          dig;
  logic [1:0]      sel;

  // all three candidate next pairs are formed in parallel
  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_cand
      bsd_step #(.RW(RW), .DIG(g - 1)) u_step (
        .s_i (s_q),
        .c_i (c_q),
        .dv_i(dv_q),
        .s_o (cand_s[g]),
        .c_o (cand_c[g])
      );
    end
  endgenerate

  bsd_select u_sel (
    .s_top(s_q[RW-2:RW-5]),
    .c_top(c_q[RW-2:RW-5]),
    .dig  (dig)
  );

  assign sel = dig.pos ? 2'd2 : (dig.neg ? 2'd0 : 2'd1);

  // finishing arithmetic: full assimilation and one-step correction
  logic [RW-1:0] v_full, v_fix;
  logic [QW-1:0] q_raw, q_fix;

  always_comb begin
    v_full = s_q + c_q;
    q_raw  = {2'b00, p_q} - {2'b00, m_q};
    if (v_full[RW-1]) begin
      v_fix = v_full + dv_q;
      q_fix = q_raw - QW'(1);
    end else if (v_full >= dv_q) begin
      v_fix = v_full - dv_q;
      q_fix = q_raw + QW'(1);
    end else begin
      v_fix = v_full;
      q_fix = q_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DV_IDLE;
      s_q     <= '0;
      c_q     <= '0;
      dv_q    <= '0;
      p_q     <= '0;
      m_q     <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        DV_IDLE: begin
          if (start_i) begin
            s_q     <= {4'b0000, dividend_i};
            c_q     <= '0;
            dv_q    <= {3'b000, divisor_i, 1'b0};
            p_q     <= '0;
            m_q     <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b1;
            state_q <= DV_RUN;
          end
        end
        DV_RUN: begin
          s_q   <= cand_s[sel];
          c_q   <= cand_c[sel];
          p_q   <= {p_q[W-2:0], dig.pos};
          m_q   <= {m_q[W-2:0], dig.neg};
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(W - 1)) state_q <= DV_FIN;
        end
        DV_FIN: begin
          quot_q  <= W'(q_fix);
          rem_q   <= W'(v_fix >> 1);
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= DV_IDLE;
        end
        default: state_q <= DV_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign quotient_o  = quot_q;
  assign remainder_o = rem_q;

endmodule

// File: rtl/bsd_divider_chk.sv
module bsd_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic [W+3:0] dv_q
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_stay_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy_o) |=> !busy_o);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_rem_below_div_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ({3'b000, remainder_o, 1'b0} < dv_q));

  assert_run_continues_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

bind bsd_divider bsd_divider_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .dv_q       (dv_q)
);

// File: tb/bsd_divider_tb_top.sv
`timescale 1ns/1ps
module bsd_divider_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bsd_divider #(.W(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one division; disturb=1 pokes start and the operands mid-run (R6)
  task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] d,
                         input string req, input bit disturb);
    longint eq, er;
    eq = (longint'(x) << (W - 1)) / longint'(d);
    er = (longint'(x) << (W - 1)) % longint'(d);
    @(negedge clk);
    dividend_i = x; divisor_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    if (disturb) begin
      start_i = 1'b1; dividend_i = ~x; divisor_i = {1'b1, ~d[W-2:0]};
      @(negedge clk);
      start_i = 1'b0; dividend_i = 8'hC3; divisor_i = 8'h81;
      repeat (W - 1) @(negedge clk);
    end else begin
      repeat (W) @(negedge clk);
    end
    check(done_o == 1'b0 && busy_o == 1'b1, "R3 not done early", done_o, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R3 done at W+1", done_o, 1);
    check(busy_o == 1'b0, "R3 busy falls with done", busy_o, 0);
    check(quotient_o == W'(eq), {req, " quotient (R4)"}, quotient_o, eq);
    check(remainder_o == W'(er), {req, " remainder (R5)"}, remainder_o, er);
  endtask

  task automatic t_reset;
    rst = 1'b1; start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 flags after reset", {busy_o, done_o}, 0);
    check(quotient_o == '0 && remainder_o == '0, "R1 results after reset",
          {quotient_o, remainder_o}, 0);
  endtask

  task automatic t_idle_and_pulse;
    run_div(8'hB0, 8'hC8, "R4", 1'b0);
    @(negedge clk);
    check(done_o == 1'b0, "R3 done one cycle", done_o, 0);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R2 stays idle without start", busy_o, 0);
  endtask

  task automatic t_hold;
    logic [W-1:0] q0, r0;
    run_div(8'hFE, 8'h93, "R4", 1'b0);
    q0 = quotient_o; r0 = remainder_o;
    @(negedge clk);
    dividend_i = 8'h80; divisor_i = 8'hFF;
    repeat (6) @(negedge clk);
    check(quotient_o == q0, "R7 quotient holds", quotient_o, q0);
    check(remainder_o == r0, "R7 remainder holds", remainder_o, r0);
  endtask

  task automatic t_disturb;
    run_div(8'h9D, 8'hE1, "R6 disturbed run", 1'b1);
    run_div(8'hFF, 8'h80, "R6 disturbed run", 1'b1);
  endtask

  task automatic t_near_equal;
    run_div(8'hA5, 8'hA5, "R8 equal", 1'b0);
    check(quotient_o == 8'h80 && remainder_o == 0, "R8 equal gives 1.0",
          quotient_o, 128);
    for (int k = 128; k < 256; k += 9) begin
      run_div(8'(k), 8'(k), "R8 equal", 1'b0);
      if (k < 255) run_div(8'(k + 1), 8'(k), "R8 x=d+1", 1'b0);
      if (k > 128) run_div(8'(k - 1), 8'(k), "R8 x=d-1", 1'b0);
    end
  endtask

  task automatic t_limits;
    run_div(8'hFF, 8'h80, "R9 max/min", 1'b0);
    check(quotient_o == 8'hFF && remainder_o == 0, "R9 max/min exact",
          quotient_o, 255);
    run_div(8'h80, 8'hFF, "R9 min/max", 1'b0);
    run_div(8'h80, 8'h80, "R9 min/min", 1'b0);
    run_div(8'hFF, 8'hFF, "R9 max/max", 1'b0);
  endtask

  task automatic t_back_to_back;
    run_div(8'hC1, 8'h87, "R10 first", 1'b0);
    // start in the very cycle after done
    dividend_i = 8'h8F; divisor_i = 8'hF3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 accepted after done", busy_o, 1);
    repeat (W + 1) @(negedge clk);
    check(done_o == 1'b1, "R10 second done", done_o, 1);
    check(quotient_o == 8'((longint'(8'h8F) << 7) / 8'hF3), "R10 quotient",
          quotient_o, (longint'(8'h8F) << 7) / 8'hF3);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x, d;
      x = 8'($urandom) | 8'h80;
      d = 8'($urandom) | 8'h80;
      run_div(x, d, "R4 random", 1'b0);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_idle_and_pulse();
    t_hold();
    t_disturb();
    t_near_equal();
    t_limits();
    t_back_to_back();
    t_random();
    report();
  end
endmodule